// File: doc/BRIEF.md
# Grey-Scale Panel Command Parser and Window Address Writer

This block sits between a serial byte link and the frame memory of a 4-bit grey-scale display. Every byte arrives with a select flag that says whether it is pixel data or part of a command. Command bytes are parsed by a small state machine. The machine reads an opcode, looks up how many argument bytes that opcode takes, and collects them. It then applies the few commands that matter to memory addressing. These commands set the column window, set the row window, and load a remap register. All the other known commands are consumed and their arguments dropped.

Data bytes are written to an external display RAM through a registered write port. Each byte holds two pixels. The address is `column + row * COLS`. After each write the address advances inside the programmed rectangle. The order is row-major by default, or column-major when remap bit 2 is set. A redraw flag tells the scan-out side that the frame has changed, and that side clears the flag with an acknowledge. A sticky flag records any opcode the parser does not know.

The state machine has two states. `ST_OPCODE` waits for an opcode and `ST_ARGS` collects arguments. There are four transitions:
- `T_OP_NOARG`: an opcode with no arguments, so the machine stays in `ST_OPCODE`.
- `T_OP_ARG`: an opcode that takes arguments, so the machine moves to `ST_ARGS`.
- `T_ARG_MORE`: an argument that is not the last one, so the machine stays in `ST_ARGS`.
- `T_ARG_LAST`: the final argument, so the command is applied and the machine returns to `ST_OPCODE`.

Data bytes never change the machine's state.

Top module: `oled_cmd_win_writer`

## Requirements
- R1: After reset the window covers columns 0 to COLS-1 and rows 0 to ROWS-1, and the pointer is at column 0, row 0. The outputs `remap_q`, `redraw`, `bad_opcode` and `ram_we` are all 0.
- R2: A byte with `is_data`=1 produces `ram_we`=1 on the next cycle, with `ram_addr` = column + row*COLS and `ram_wdata` equal to the byte. A byte with `is_data`=0 never asserts `ram_we`.
- R3: With remap bit 2 clear, the column advances after each write. A write at or past the column end returns the column to the column start and advances the row. A row at or past the row end returns to the row start.
- R4: With remap bit 2 set, the row advances after each write. A write at or past the row end returns the row to the row start and advances the column. A column at or past the column end returns to the column start.
- R5: Opcode 0x15 takes two arguments. The first is the column start and the second is the column end, each reduced modulo COLS. The pointer column is set to the start.
- R6: Opcode 0x75 takes two arguments. The first is the row start and the second is the row end, each reduced modulo ROWS. The pointer row is set to the start.
- R7: The parser consumes a fixed number of argument bytes for each opcode, and none of those bytes is taken as an opcode.
  - Eight arguments: 0xB8.
  - One argument: 0x81, 0xA0, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF.
  - No arguments: 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3.
- R8: The single argument of opcode 0xA0 is loaded into `remap_q`. `remap_q` changes on no other byte.
- R9: Opcode 0xFF takes no arguments and does not set `bad_opcode`. Any other unlisted opcode is treated as taking no arguments and sets `bad_opcode`, which stays set until reset.
- R10: `redraw` is set by every data write. It is cleared on the cycle after `redraw_ack` is high with no data byte present. If a data byte and the acknowledge arrive together, `redraw` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A byte is present this cycle |
| is_data | input | 1 | 1: pixel data, 0: opcode or argument |
| byte_in | input | 8 | Incoming byte |
| redraw_ack | input | 1 | Scan-out side has taken the frame |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | $clog2(COLS*ROWS) | Display RAM byte address |
| ram_wdata | output | 8 | Two packed 4-bit pixels |
| remap_q | output | 8 | Remap register; bit 2 selects vertical increment |
| redraw | output | 1 | Frame changed since last acknowledge |
| bad_opcode | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench builds the block with its default geometry of 64 columns by 80 rows, so the address is 13 bits wide. With 80 rows, modulo reduction of row arguments between 80 and 255 gives real wrap values, for example 245 reduces to 5. With 64 columns, arguments of 64 and above fold onto small column numbers. A full-width horizontal sweep reaches the row carry at column 63. Small windows with start greater than end, and swaps between horizontal and vertical order in the middle of a window, reach every wrap branch in a few hundred bytes.

// File: rtl/oled_cw_pkg.sv
package oled_cw_pkg;

    typedef enum logic [0:0] {
        ST_OPCODE,
        ST_ARGS
    } fsm_state_t;

    typedef enum logic [2:0] {
        K_COLWIN,
        K_ROWWIN,
        K_REMAP,
        K_SKIP,
        K_FILLER,
        K_UNKNOWN
    } op_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [3:0] nargs;
    } op_info_t;

    localparam logic [7:0] OP_COLWIN = 8'h15;
    localparam logic [7:0] OP_ROWWIN = 8'h75;
    localparam logic [7:0] OP_REMAP  = 8'hA0;
    localparam logic [7:0] OP_GREY   = 8'hB8;
    localparam logic [7:0] OP_FILLER = 8'hFF;

    localparam int REMAP_VERT_BIT = 2;

endpackage

// File: rtl/oled_cw_opdec.sv
module oled_cw_opdec
    import oled_cw_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);

    always_comb begin
        info.kind  = K_SKIP;
        info.nargs = 4'd0;
        case (opcode)
            OP_COLWIN: begin
                info.kind  = K_COLWIN;
                info.nargs = 4'd2;
            end
            OP_ROWWIN: begin
                info.kind  = K_ROWWIN;
                info.nargs = 4'd2;
            end
            OP_REMAP: begin
                info.kind  = K_REMAP;
                info.nargs = 4'd1;
            end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: begin
                info.kind  = K_SKIP;
                info.nargs = 4'd1;
            end
            OP_GREY: begin
                info.kind  = K_SKIP;
                info.nargs = 4'd8;
            end
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3: begin
                info.kind  = K_SKIP;
                info.nargs = 4'd0;
            end
            OP_FILLER: begin
                info.kind  = K_FILLER;
                info.nargs = 4'd0;
            end
            default: begin
                info.kind  = K_UNKNOWN;
                info.nargs = 4'd0;
            end
        endcase
    end

endmodule

// File: rtl/oled_cw_cmd_fsm.sv
module oled_cw_cmd_fsm
    import oled_cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_stb,
    input  logic [7:0] cmd_byte,
    output logic       col_load,
    output logic       row_load,
    output logic       remap_load,
    output logic [7:0] arg_first,
    output logic [7:0] arg_last,
    output logic       bad_op
);

    fsm_state_t state_q, state_d;
    op_kind_t   kind_q, kind_d;
    logic [3:0] need_q, need_d;
    logic [3:0] idx_q, idx_d;
    logic [7:0] arg0_q, arg0_d;
    op_info_t   info;
    logic       last_arg;

    oled_cw_opdec u_dec (
        .opcode (cmd_byte),
        .info   (info)
    );

    assign last_arg = (idx_q == 4'(need_q - 4'd1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            kind_q  <= K_SKIP;
            need_q  <= 4'd0;
            idx_q   <= 4'd0;
            arg0_q  <= 8'd0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            need_q  <= need_d;
            idx_q   <= idx_d;
            arg0_q  <= arg0_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        need_d  = need_q;
        idx_d   = idx_q;
        arg0_d  = arg0_q;
        if (cmd_stb) begin
            unique case (state_q)
                ST_OPCODE: begin
                    kind_d = info.kind;
                    need_d = info.nargs;
                    idx_d  = 4'd0;
                    if (info.nargs != 4'd0) begin
                        state_d = ST_ARGS;      // T_OP_ARG
                    end                          // else T_OP_NOARG
                end
                ST_ARGS: begin
                    if (idx_q == 4'd0) begin
                        arg0_d = cmd_byte;
                    end
                    if (last_arg) begin
                        state_d = ST_OPCODE;    // T_ARG_LAST
                    end else begin
                        idx_d = 4'(idx_q + 4'd1); // T_ARG_MORE
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        col_load   = 1'b0;
        row_load   = 1'b0;
        remap_load = 1'b0;
        bad_op     = 1'b0;
        arg_first  = arg0_q;
        arg_last   = cmd_byte;
        if (cmd_stb) begin
            unique case (state_q)
                ST_OPCODE: begin
                    bad_op = (info.kind == K_UNKNOWN);
                end
                ST_ARGS: begin
                    if (last_arg) begin
                        col_load   = (kind_q == K_COLWIN);
                        row_load   = (kind_q == K_ROWWIN);
                        remap_load = (kind_q == K_REMAP);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/oled_cw_addr_walk.sv
module oled_cw_addr_walk #(
    parameter int COLS = 64,
    parameter int ROWS = 80
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_stb,
    input  logic [7:0]                        wr_byte,
    input  logic                              vertical,
    input  logic                              col_load,
    input  logic                              row_load,
    input  logic [7:0]                        arg_first,
    input  logic [7:0]                        arg_last,
    output logic                              ram_we,
    output logic [$clog2(COLS*ROWS)-1:0]      ram_addr,
    output logic [7:0]                        ram_wdata
);

    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = $clog2(COLS * ROWS);

    logic [COL_W-1:0] col_q, col_lo_q, col_hi_q, col_nx;
    logic [ROW_W-1:0] row_q, row_lo_q, row_hi_q, row_nx;
    logic [COL_W-1:0] c_first, c_last;
    logic [ROW_W-1:0] r_first, r_last;
    logic [ADDR_W-1:0] addr_now;

    assign c_first = COL_W'({24'd0, arg_first} % COLS);
    assign c_last  = COL_W'({24'd0, arg_last}  % COLS);
    assign r_first = ROW_W'({24'd0, arg_first} % ROWS);
    assign r_last  = ROW_W'({24'd0, arg_last}  % ROWS);

    generate
        if ((1 << COL_W) == COLS) begin : g_pow2
            if (ADDR_W == COL_W + ROW_W) begin : g_cat
                assign addr_now = {row_q, col_q};
            end else begin : g_trim
                assign addr_now = ADDR_W'({row_q, col_q});
            end
        end else begin : g_mul
            assign addr_now = ADDR_W'(col_q) + ADDR_W'(row_q) * ADDR_W'(COLS);
        end
    endgenerate

    always_comb begin
        col_nx = col_q;
        row_nx = row_q;
        if (vertical) begin
            if (row_q >= row_hi_q) begin
                row_nx = row_lo_q;
                col_nx = (col_q >= col_hi_q) ? col_lo_q : COL_W'(col_q + 1'b1);
            end else begin
                row_nx = ROW_W'(row_q + 1'b1);
            end
        end else begin
            if (col_q >= col_hi_q) begin
                col_nx = col_lo_q;
                row_nx = (row_q >= row_hi_q) ? row_lo_q : ROW_W'(row_q + 1'b1);
            end else begin
                col_nx = COL_W'(col_q + 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            col_lo_q  <= '0;
            col_hi_q  <= COL_W'(COLS - 1);
            row_q     <= '0;
            row_lo_q  <= '0;
            row_hi_q  <= ROW_W'(ROWS - 1);
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= 8'd0;
        end else begin
            ram_we <= wr_stb;
            if (wr_stb) begin
                ram_addr  <= addr_now;
                ram_wdata <= wr_byte;
                col_q     <= col_nx;
                row_q     <= row_nx;
            end
            if (col_load) begin
                col_lo_q <= c_first;
                col_hi_q <= c_last;
                col_q    <= c_first;
            end
            if (row_load) begin
                row_lo_q <= r_first;
                row_hi_q <= r_last;
                row_q    <= r_first;
            end
        end
    end

endmodule

// File: rtl/oled_cmd_win_writer.sv
module oled_cmd_win_writer
    import oled_cw_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_valid,
    input  logic                          is_data,
    input  logic [7:0]                    byte_in,
    input  logic                          redraw_ack,
    output logic                          ram_we,
    output logic [$clog2(COLS*ROWS)-1:0]  ram_addr,
    output logic [7:0]                    ram_wdata,
    output logic [7:0]                    remap_q,
    output logic                          redraw,
    output logic                          bad_opcode
);

    logic       data_stb, cmd_stb;
    logic       col_load, row_load, remap_load, bad_op;
    logic [7:0] arg_first, arg_last;

    assign data_stb = byte_valid &  is_data;
    assign cmd_stb  = byte_valid & ~is_data;

    oled_cw_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .cmd_byte   (byte_in),
        .col_load   (col_load),
        .row_load   (row_load),
        .remap_load (remap_load),
        .arg_first  (arg_first),
        .arg_last   (arg_last),
        .bad_op     (bad_op)
    );

    oled_cw_addr_walk #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (data_stb),
        .wr_byte   (byte_in),
        .vertical  (remap_q[REMAP_VERT_BIT]),
        .col_load  (col_load),
        .row_load  (row_load),
        .arg_first (arg_first),
        .arg_last  (arg_last),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q    <= 8'd0;
            redraw     <= 1'b0;
            bad_opcode <= 1'b0;
        end else begin
            if (remap_load) begin
                remap_q <= arg_last;
            end
            if (data_stb) begin
                redraw <= 1'b1;
            end else if (redraw_ack) begin
                redraw <= 1'b0;
            end
            if (bad_op) begin
                bad_opcode <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/oled_cmd_win_writer_chk.sv
module oled_cmd_win_writer_chk #(
    parameter int COLS = 64,
    parameter int ROWS = 80
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          byte_valid,
    input logic                          is_data,
    input logic [7:0]                    byte_in,
    input logic                          redraw_ack,
    input logic                          ram_we,
    input logic [$clog2(COLS*ROWS)-1:0]  ram_addr,
    input logic [7:0]                    ram_wdata,
    input logic [7:0]                    remap_q,
    input logic                          redraw,
    input logic                          bad_opcode
);

    localparam int ADDR_W = $clog2(COLS * ROWS);
    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W + 1)'(COLS * ROWS);

    p_addr_in_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ram_addr} < ADDR_LIMIT));

    p_data_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_data) |=> (ram_we && ram_wdata == $past(byte_in)));

    p_no_write_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && is_data) |=> !ram_we);

    p_remap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && !is_data) |=> $stable(remap_q));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |=> bad_opcode);

    p_redraw_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> redraw);

    p_redraw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (redraw_ack && !(byte_valid && is_data)) |=> !redraw);

endmodule

bind oled_cmd_win_writer oled_cmd_win_writer_chk #(
    .COLS (COLS),
    .ROWS (ROWS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .is_data    (is_data),
    .byte_in    (byte_in),
    .redraw_ack (redraw_ack),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .remap_q    (remap_q),
    .redraw     (redraw),
    .bad_opcode (bad_opcode)
);

// File: tb/oled_cmd_win_writer_tb_top.sv
module oled_cmd_win_writer_tb_top;

    localparam int COLS = 64;
    localparam int ROWS = 80;
    localparam int AW   = $clog2(COLS * ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_valid = 1'b0;
    logic          is_data = 1'b0;
    logic [7:0]    byte_in = 8'd0;
    logic          redraw_ack = 1'b0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic [7:0]    remap_q;
    logic          redraw;
    logic          bad_opcode;

    always #10 clk = ~clk;

    oled_cmd_win_writer #(.COLS(COLS), .ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .is_data(is_data),
        .byte_in(byte_in), .redraw_ack(redraw_ack), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .remap_q(remap_q),
        .redraw(redraw), .bad_opcode(bad_opcode)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int m_col, m_row, m_cs, m_ce, m_rs, m_re, m_remap;
    int m_left, m_idx, m_a0;
    int m_op;
    bit m_err, m_redraw;

    function automatic int arg_count(input int op);
        if (op == 8'h15 || op == 8'h75) return 2;
        if (op == 8'hB8) return 8;
        if (op == 8'h81 || op == 8'hA0 || op == 8'hA1 || op == 8'hA2 || op == 8'hA8 ||
            op == 8'hAD || op == 8'hB1 || op == 8'hB2 || op == 8'hB3 || op == 8'hBC ||
            op == 8'hBE || op == 8'hBF) return 1;
        if ((op >= 8'h84 && op <= 8'h86) || (op >= 8'hA4 && op <= 8'hA7) ||
            op == 8'hAE || op == 8'hAF || op == 8'hE3 || op == 8'hFF) return 0;
        return -1;
    endfunction

    function automatic int exp_addr();
        return m_col + m_row * COLS;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_col = 0; m_row = 0; m_cs = 0; m_ce = COLS - 1; m_rs = 0; m_re = ROWS - 1;
        m_remap = 0; m_left = 0; m_idx = 0; m_a0 = 0; m_op = 0;
        m_err = 0; m_redraw = 0;
    endtask

    task automatic model_cmd(input int b);
        int n;
        if (m_left == 0) begin
            n = arg_count(b);
            if (n < 0) begin
                m_err = 1;
                n = 0;
            end
            m_op = b; m_left = n; m_idx = 0;
        end else begin
            if (m_idx == 0) m_a0 = b;
            m_idx++;
            m_left--;
            if (m_left == 0) begin
                if (m_op == 8'h15) begin
                    m_cs = m_a0 % COLS; m_ce = b % COLS; m_col = m_cs;
                end else if (m_op == 8'h75) begin
                    m_rs = m_a0 % ROWS; m_re = b % ROWS; m_row = m_rs;
                end else if (m_op == 8'hA0) begin
                    m_remap = b;
                end
            end
        end
    endtask

    task automatic model_advance();
        if (m_remap[2]) begin
            m_row++;
            if (m_row > m_re) begin
                m_row = m_rs;
                m_col++;
            end
            if (m_col > m_ce) m_col = m_cs;
        end else begin
            m_col++;
            if (m_col > m_ce) begin
                m_col = m_cs;
                m_row++;
            end
            if (m_row > m_re) m_row = m_rs;
        end
    endtask

    // one byte, one idle cycle; outputs checked on the following falling edge
    task automatic send(input bit d, input int b, input bit ack, input string tag);
        int ea;
        ea = exp_addr();
        @(negedge clk);
        byte_valid = 1'b1; is_data = d; byte_in = 8'(b); redraw_ack = ack;
        @(negedge clk);
        byte_valid = 1'b0; is_data = 1'b0; redraw_ack = 1'b0;
        if (d) begin
            m_redraw = 1;
            chk(ram_we == 1'b1, {tag, " R2 we"}, int'(ram_we), 1);
            chk(int'(ram_addr) == ea, {tag, " R2/R3/R4 addr"}, int'(ram_addr), ea);
            chk(int'(ram_wdata) == b, {tag, " R2 wdata"}, int'(ram_wdata), b);
            model_advance();
        end else begin
            if (ack) m_redraw = 0;
            model_cmd(b);
            chk(ram_we == 1'b0, {tag, " R2 no write on cmd"}, int'(ram_we), 0);
            chk(int'(remap_q) == m_remap, {tag, " R8 remap"}, int'(remap_q), m_remap);
            chk(bad_opcode == m_err, {tag, " R9 bad_opcode"}, int'(bad_opcode), int'(m_err));
        end
        chk(redraw == m_redraw, {tag, " R10 redraw"}, int'(redraw), int'(m_redraw));
    endtask

    task automatic ack_only();
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
        m_redraw = 0;
        chk(redraw == 1'b0, "R10 ack clears", int'(redraw), 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0323);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ram_we == 1'b0, "R1 ram_we", int'(ram_we), 0);
        chk(remap_q == 8'd0, "R1 remap", int'(remap_q), 0);
        chk(redraw == 1'b0, "R1 redraw", int'(redraw), 0);
        chk(bad_opcode == 1'b0, "R1 bad_opcode", int'(bad_opcode), 0);

        // R1/R3: full first row, then carry into row 1
        for (int i = 0; i < COLS + 2; i++) send(1, i, 0, "R1/R3 sweep");

        // R10: ack alone clears; ack with data keeps set
        ack_only();
        send(1, 8'h5A, 1, "R10 ack+data");

        // R5/R6: modulo window, three columns by two rows, wrap to start
        send(0, 8'h15, 0, "R5 op"); send(0, 8'h45, 0, "R5 a0"); send(0, 8'h47, 0, "R5 a1");
        send(0, 8'h75, 0, "R6 op"); send(0, 8'hF5, 0, "R6 a0"); send(0, 8'h56, 0, "R6 a1");
        for (int i = 0; i < 8; i++) send(1, 8'hA0 + i, 0, "R5/R6 window");

        // R4/R8: vertical order
        send(0, 8'hA0, 0, "R8 op"); send(0, 8'h04, 0, "R8 arg");
        for (int i = 0; i < 7; i++) send(1, i, 0, "R4 vertical");

        // R7: eight arguments that look like opcodes
        send(0, 8'hB8, 0, "R7 op");
        for (int i = 0; i < 8; i++) send(0, (i % 2) ? 8'h75 : 8'h15, 0, "R7 arg");
        send(0, 8'h81, 0, "R7 one-arg op"); send(0, 8'hA0, 0, "R7 swallowed");
        send(0, 8'hE3, 0, "R7 no-arg");
        send(1, 8'h11, 0, "R7 after skip");

        // R9: filler does not flag, unknown flags and takes no argument
        send(0, 8'hFF, 0, "R9 filler");
        send(0, 8'h00, 0, "R9 unknown");
        send(0, 8'h15, 0, "R9 next is opcode"); send(0, 8'h02, 0, "R9 a0"); send(0, 8'h03, 0, "R9 a1");
        send(1, 8'h22, 0, "R9 data");
        send(0, 8'hE3, 0, "R9 sticky");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (m_left != 0) begin
                send(0, int'($urandom_range(0, 255)), 0, "R7 rnd arg");
            end else if (r < 5) begin
                send(1, int'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0), "R3/R4 rnd data");
            end else if (r == 5) begin
                send(0, 8'h15, 0, "R5 rnd");
            end else if (r == 6) begin
                send(0, 8'h75, 0, "R6 rnd");
            end else if (r == 7) begin
                send(0, 8'hA0, 0, "R8 rnd");
            end else if (r == 8) begin
                send(0, 8'hB8, 1, "R7 rnd grey");
            end else begin
                send(0, 8'hFF, 0, "R9 rnd filler");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule